// File: doc/BRIEF.md
# UART Receive Staging FIFO with Fill-Level Interrupt

This block sits between a UART deserializer and the software read path. Each time the deserializer finishes a character, it pulses a one-cycle strobe. The strobe carries the data byte and two error tags, one for parity and one for framing. The block stores the character in a small FIFO that holds four entries. Software drains the FIFO through a read port. The read port shows the oldest character together with the error tags that came in with it.

A two-bit mode input sets how full the FIFO must be before the block raises a receive interrupt. The block checks the fill level only in the cycle in which a character enters the FIFO. Reads, idle cycles and dropped characters never raise the interrupt.

The deserializer cannot be stalled, so the write side has no ready signal. A character that arrives when the FIFO has no room is lost, and the block sets a sticky overrun flag. Software clears the flag with a one-cycle pulse, and that pulse also empties the FIFO.

The read side is a valid/ready port:
- `rd_valid` is high whenever the FIFO holds at least one entry.
- An entry is removed on a clock edge where both `rd_valid` and `rd_ready` are high.
- `rd_ready` may be held high while `rd_valid` is low, and it then has no effect.
- The head data and tags stay stable until that entry is removed.

Top module: `rxq_stage`

## Requirements
- R1: After reset, the FIFO is empty: `rd_valid`, `irq` and `ovr` are all 0.
- R2: A byte that arrives while the FIFO holds fewer than 4 entries is stored. Entries leave in arrival order. `rd_valid` is 1 exactly when the FIFO is not empty.
- R3: An entry is removed only on a clock edge with `rd_valid` and `rd_ready` both high. `rd_ready` while the FIFO is empty changes nothing.
- R4: `rd_perr` and `rd_ferr` show the parity and framing tags that arrived with the entry currently at the head.
- R5: With `mode` 2'b00 or 2'b01, `irq` is high for exactly one cycle, in the cycle after each byte is stored.
- R6: With `mode` 2'b10, `irq` pulses for one cycle after a store only when that store leaves 3 entries in the FIFO.
- R7: With `mode` 2'b11, `irq` pulses for one cycle after a store only when that store leaves 4 entries in the FIFO.
- R8: No `irq` pulse follows a cycle in which no byte was stored. This holds when a read lowers the fill level to the threshold and when a byte is dropped.
- R9: A byte that arrives while the FIFO holds 4 entries, with no read and no clear in the same cycle, is discarded and the FIFO contents are unchanged. `ovr` then rises and stays high until it is cleared.
- R10: A byte that arrives while the FIFO is full, in the same cycle as a read, is stored and does not set `ovr`.
- R11: A pulse on `ovr_clr` drives `ovr` low and empties the FIFO. A byte that arrives in the same cycle is kept as the only entry and counts as a store that leaves 1 entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Interrupt threshold: 0x any store, 10 three entries, 11 four entries |
| in_valid | input | 1 | One-cycle strobe: a completed character is present |
| in_data | input | 8 | Received character |
| in_perr | input | 1 | Parity error tag for the character |
| in_ferr | input | 1 | Framing error tag for the character |
| rd_valid | output | 1 | FIFO not empty; head entry is on the read port |
| rd_ready | input | 1 | Consumer takes the head entry |
| rd_data | output | 8 | Head character |
| rd_perr | output | 1 | Parity tag of the head entry |
| rd_ferr | output | 1 | Framing tag of the head entry |
| irq | output | 1 | One-cycle receive interrupt pulse |
| ovr | output | 1 | Sticky overrun flag |
| ovr_clr | input | 1 | Clears `ovr` and flushes the FIFO |

## Verification
The threshold logic is driven in three ways:
- Slowly spaced single bytes in each mode show the any, three-entry and four-entry conditions apart.
- Reads that lower the level back to the threshold separate an event-driven interrupt from one that follows the level.
- Bursts into a full FIFO, with and without a read in the same cycle, separate dropping a byte from accepting it.

A clear that coincides with an arriving byte checks that the flush and the store keep their order. A long random phase with mode changes compares every output, on every cycle, against a queue-based model.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef enum logic [1:0] {
    RXQ_ANY_A   = 2'b00,
    RXQ_ANY_B   = 2'b01,
    RXQ_THREE_Q = 2'b10,
    RXQ_FULL    = 2'b11
  } rxq_mode_e;

  localparam int unsigned RXQ_TAG_W = 2;

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned EW    = 10,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [EW-1:0] wdata_i,
  input  logic          pop_i,
  input  logic          flush_i,
  output logic [EW-1:0] rdata_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);

  logic [EW-1:0] slot_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == CW'(0));
  assign count_o = cnt_q;
  assign rdata_o = slot_q[rp_q];

  // Per-slot write enable; a flush redirects the write to slot zero.
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic we;
    assign we = push_i && (flush_i ? (g == 0) : (wp_q == AW'(g)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  slot_q[g] <= '0;
      else if (we) slot_q[g] <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wp_q  <= AW'(push_i);
      rp_q  <= '0;
      cnt_q <= CW'(push_i);
    end else begin
      if (push_i) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + AW'(1);
      if (pop_i)  rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + AW'(1);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  AST_NO_WRITE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && !pop_i && !flush_i) |-> !push_i); // R9
  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> !empty_o); // R3
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_i && !push_i) |=> empty_o); // R11

endmodule

// File: rtl/rxq_thresh.sv
module rxq_thresh #(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CW      = $clog2(DEPTH + 1),
  localparam int unsigned THREE_Q = (DEPTH * 3) / 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode_i,
  input  logic          xfer_i,
  input  logic [CW-1:0] fill_i,
  output logic          irq_o
);
  import rxq_pkg::*;

  rxq_mode_e md;
  logic      hit;

  assign md = rxq_mode_e'(mode_i);

  always_comb begin
    unique case (md)
      RXQ_THREE_Q: hit = (fill_i == CW'(THREE_Q));
      RXQ_FULL:    hit = (fill_i == CW'(DEPTH));
      default:     hit = (fill_i != CW'(0));
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= xfer_i && hit;
  end

  AST_IRQ_ONLY_ON_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(xfer_i)); // R8
  AST_IRQ_ONE_CYCLE_ANY: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_i && !mode_i[1]) |=> irq_o); // R5

endmodule

// File: rtl/rxq_ovr.sv
module rxq_ovr (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic ovr_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ovr_o <= 1'b0;
    else if (clr_i) ovr_o <= 1'b0;
    else if (set_i) ovr_o <= 1'b1;
  end

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_o && !clr_i) |=> ovr_o); // R9
  AST_OVR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !ovr_o); // R11

endmodule

// File: rtl/rxq_stage.sv
module rxq_stage #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 4,
  localparam int unsigned EW    = DATA_W + rxq_pkg::RXQ_TAG_W,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_perr,
  input  logic              in_ferr,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_perr,
  output logic              rd_ferr,
  output logic              irq,
  output logic              ovr,
  input  logic              ovr_clr
);

  logic          pop, push, drop, full, empty;
  logic [CW-1:0] count, fill_after;
  logic [EW-1:0] head;

  assign rd_valid = !empty;
  assign pop      = rd_valid && rd_ready;
  // A byte finds room if a slot is free, a read frees one, or a flush empties all.
  assign push     = in_valid && (!full || pop || ovr_clr);
  assign drop     = in_valid && !push;
  assign fill_after = ovr_clr ? CW'(1) : (count - CW'(pop) + CW'(1));

  rxq_store #(.DEPTH(DEPTH), .EW(EW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (push),
    .wdata_i ({in_ferr, in_perr, in_data}),
    .pop_i   (pop),
    .flush_i (ovr_clr),
    .rdata_o (head),
    .count_o (count),
    .full_o  (full),
    .empty_o (empty)
  );

  rxq_thresh #(.DEPTH(DEPTH)) u_thresh (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode_i (mode),
    .xfer_i (push),
    .fill_i (fill_after),
    .irq_o  (irq)
  );

  rxq_ovr u_ovr (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (drop),
    .clr_i (ovr_clr),
    .ovr_o (ovr)
  );

  assign rd_data = head[DATA_W-1:0];
  assign rd_perr = head[DATA_W];
  assign rd_ferr = head[DATA_W+1];

  AST_HEAD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !ovr_clr && !$isunknown(head)) |=> $stable(head)); // R4
  AST_DROP_SETS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && full && !rd_ready && !ovr_clr) |=> ovr); // R9

endmodule

// File: tb/rxq_stage_tb_top.sv
module rxq_stage_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_perr = 1'b0, in_ferr = 1'b0;
  logic       rd_ready = 1'b0, ovr_clr = 1'b0;
  logic       rd_valid, rd_perr, rd_ferr, irq, ovr;
  logic [7:0] rd_data;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rxq_stage dut_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .in_valid(in_valid), .in_data(in_data),
    .in_perr(in_perr), .in_ferr(in_ferr), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .rd_perr(rd_perr), .rd_ferr(rd_ferr), .irq(irq), .ovr(ovr),
    .ovr_clr(ovr_clr)
  );

  // Reference model
  logic [9:0] mq [$];
  bit    e_irq = 0, e_ovr = 0;
  string e_tag = "R5";

  function automatic bit hit(logic [1:0] m, int n);
    if (!m[1]) return 1'b1;
    return m[0] ? (n == 4) : (n == 3);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete(); e_irq = 0; e_ovr = 0;
    end else begin
      automatic bit pop = rd_ready && (mq.size() != 0);
      automatic bit full = (mq.size() == 4);
      e_tag = !mode[1] ? "R5" : (mode[0] ? "R7" : "R6");
      e_irq = 0;
      if (ovr_clr) begin
        mq.delete(); e_ovr = 0;
        if (in_valid) begin
          mq.push_back({in_ferr, in_perr, in_data});
          e_irq = hit(mode, 1);
        end
      end else begin
        if (pop) void'(mq.pop_front());
        if (in_valid) begin
          if (!full || pop) begin
            mq.push_back({in_ferr, in_perr, in_data});
            e_irq = hit(mode, mq.size());
          end else begin
            e_ovr = 1;
            e_tag = "R8";
          end
        end
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Compare against the model 2 ns after every rising edge
  always @(posedge clk) begin
    #2;
    if (!done) begin
      chk("R2 rd_valid", rd_valid, mq.size() != 0);
      if (mq.size() != 0) begin
        chk("R2 rd_data", rd_data, mq[0][7:0]);
        chk("R4 rd_perr", rd_perr, mq[0][8]);
        chk("R4 rd_ferr", rd_ferr, mq[0][9]);
      end
      chk({e_tag, " irq"}, irq, e_irq);
      chk("R9 ovr", ovr, e_ovr);
    end
  end

  task automatic step(bit v, logic [7:0] d, bit pe, bit fe, bit rr, bit clr);
    @(negedge clk);
    in_valid = v; in_data = d; in_perr = pe; in_ferr = fe;
    rd_ready = rr; ovr_clr = clr;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 8'h00, 0, 0, 0, 0);
  endtask

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 irq", irq, 0);
    chk("R1 ovr", ovr, 0);
    rst_n = 1'b1;
    idle(2);

    // R5: any-store mode, spaced and back-to-back
    mode = 2'b00;
    step(1, 8'hA1, 1, 0, 0, 0); idle(2);
    step(1, 8'hA2, 0, 1, 0, 0); step(1, 8'hA3, 0, 0, 0, 0); idle(1);
    mode = 2'b01;
    step(1, 8'hA4, 1, 1, 0, 0); idle(2);
    for (int i = 0; i < 4; i++) step(0, 8'h00, 0, 0, 1, 0);
    idle(1);
    // R3: read on empty FIFO has no effect
    step(0, 8'h00, 0, 0, 1, 0); idle(1);
    @(negedge clk); chk("R3 empty read", rd_valid, 0);

    // R6: three-quarter mode, then R8 on read back to three
    mode = 2'b10;
    for (int i = 0; i < 4; i++) step(1, 8'hB0 + 8'(i), 0, 0, 0, 0);
    idle(2);
    step(0, 8'h00, 0, 0, 1, 0); idle(2);
    @(negedge clk); chk("R8 no irq on read", irq, 0);
    for (int i = 0; i < 3; i++) step(0, 8'h00, 0, 0, 1, 0);
    step(1, 8'hB8, 0, 0, 0, 0); step(1, 8'hB9, 0, 0, 0, 0);
    step(1, 8'hBA, 0, 0, 0, 0); idle(2);

    // R7: full mode
    mode = 2'b11;
    step(0, 8'h00, 0, 0, 1, 0); idle(1);
    step(1, 8'hC0, 0, 1, 0, 0); idle(1);
    step(1, 8'hC1, 1, 0, 0, 0); idle(2);
    @(negedge clk); chk("R7 full count", rd_valid, 1);

    // R9: drop while full, no read
    step(1, 8'hDD, 1, 1, 0, 0); idle(1);
    @(negedge clk); chk("R9 ovr set", ovr, 1);
    step(1, 8'hDE, 0, 0, 0, 0); idle(3);
    @(negedge clk); chk("R9 ovr sticky", ovr, 1);

    // R10: full plus simultaneous read accepts the byte
    step(1, 8'hE0, 0, 0, 1, 0); idle(2);
    for (int i = 0; i < 2; i++) step(0, 8'h00, 0, 0, 1, 0);
    idle(1);

    // R11: clear with a coincident byte, then a clear alone
    step(1, 8'hF1, 1, 0, 0, 1); idle(1);
    @(negedge clk); chk("R11 ovr cleared", ovr, 0);
    chk("R11 single entry", rd_data, 8'hF1);
    step(0, 8'h00, 0, 0, 1, 0); idle(1);
    @(negedge clk); chk("R11 one entry only", rd_valid, 0);
    step(1, 8'hF2, 0, 0, 0, 0); step(1, 8'hF3, 0, 0, 0, 0);
    step(0, 8'h00, 0, 0, 0, 1); idle(1);
    @(negedge clk); chk("R11 flushed", rd_valid, 0);

    // Random phase across all modes
    for (int i = 0; i < 2000; i++) begin
      if (i % 97 == 0) mode = 2'($urandom_range(0, 3));
      step(($urandom_range(0, 99) < 45), 8'($urandom), 1'($urandom), 1'($urandom),
           ($urandom_range(0, 99) < 35), ($urandom_range(0, 99) < 2));
    end
    idle(3);
    finish_run();
  end

endmodule